// File: doc/BRIEF.md
# Warp Scratchpad Bank Conflict Resolver

This block takes one shared-scratchpad access issued on behalf of a whole group of 32 lanes and carries it out against a memory split into 32 banks. Each bank is 8 bytes wide. Every active lane supplies a byte address. The block decodes that address into a bank number and a row inside the bank. A bank can deliver one 8-byte entry per cycle. When several lanes need different rows of the same bank, the access cannot finish in one cycle, so the block spreads it over as many passes as the worst bank needs. Lanes that need the same entry are served together.

A mode input picks one of two address-to-bank mappings. In 8-byte mode, consecutive 8-byte words go to consecutive banks. In 4-byte mode, consecutive 4-byte words go to consecutive banks, and one more address bit selects the lower or upper half of the 8-byte entry. Both halves of one entry are fetched together, so they never conflict. Reads multicast a fetched entry to every lane that asked for any part of it. For writes to one location, the lowest-numbered lane wins. The bank storage is modelled inside the block as plain arrays.

The caller offers an access with a valid/ready handshake and then watches three outputs. The per-pass bank request vector shows which banks are busy in each pass. A done strobe marks the final pass. The replay count reads zero in the first pass and rises by one each pass after that.

Top module: `spad_conflict_resolver`

## Requirements
- R1: In 8-byte mode, the bank is address bits [7:3], the row is the bits above bit 7 (bits [13:8] with default parameters), and bits [2:0] are ignored. Lanes with pairwise distinct banks finish in a single pass.
- R2: In 4-byte mode, the bank is address bits [6:2], bit 7 selects the half of the entry (0 = bits [31:0], 1 = bits [63:32]), the row is the bits above bit 7, and bits [1:0] are ignored.
- R3: Active lanes that target the same bank and the same row never conflict, whatever their byte offsets and whichever halves they select. On a read, all of them receive the fetched entry.
- R4: The number of replays equals the largest count of distinct rows that active lanes request within one bank, minus one, or zero if no lane is active. The number of passes is the replay count plus one. `acc_replays` reads 0 in the first pass and increases by exactly one in each following pass.
- R5: In each pass, bit b of `bank_req` is set exactly when some still-pending lane targets bank b. That bank serves the row of its lowest-numbered pending lane, so lanes that collide in one bank complete in ascending lane order.
- R6: When several active lanes write the same location in one access, the stored value is the data of the lowest-numbered of those lanes.
- R7: Lanes whose mask bit is 0 add no conflict, write nothing, and keep their `lane_rdata` unchanged. An access with an empty mask takes exactly one pass with no bank requested.
- R8: An access is accepted in a cycle where `acc_valid` and `acc_ready` are both 1. `acc_ready` is 0 from the next cycle until the cycle after the final pass. `acc_done` is 1 only in that final pass cycle. Read results appear on `lane_rdata` in the cycle after `acc_done`.
- R9: After reset, `acc_ready` is 1, `acc_done` is 0, and `bank_req`, `acc_replays` and `lane_rdata` are all zero.
- R10: In 4-byte mode, a read returns the selected half in bits [31:0] with bits [63:32] zero, and a write stores `wdata[31:0]` into the selected half only. In 8-byte mode, reads and writes move the full 64-bit entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block idle, can accept an access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_wide | input | 1 | 1 = 8-byte bank mapping, 0 = 4-byte mapping |
| acc_mask | input | LANES | Per-lane active bits |
| acc_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane t at bits [t*ADDR_W +: ADDR_W] |
| acc_wdata | input | LANES*64 | Per-lane write data, lane t at bits [t*64 +: 64] |
| bank_req | output | BANKS | Banks accessed in the current pass |
| acc_done | output | 1 | Final pass of the current access |
| acc_replays | output | $clog2(LANES) | Pass index; equals the replay count when acc_done is 1 |
| lane_rdata | output | LANES*64 | Per-lane read results, lane t at bits [t*64 +: 64] |

## Verification
The bench uses the default parameters: 32 lanes, 32 banks and 64 rows per bank. This is large enough for a full-width 32-way collision and for a 32x32 matrix of 8-byte elements stored with a padded row stride of 33. The column walk over that matrix yields 31 replays with stride 32 and none with stride 33. A conflict-degree sweep from 1 to 32, same-entry multicast with mixed byte offsets and halves, and masked, empty and same-address write accesses all fit within the 2048-entry store. The bench predicts each replay count by counting distinct rows per bank in its own shadow model. It predicts each read result from the same shadow model.

// File: rtl/spad_pkg.sv
package spad_pkg;
    localparam int unsigned ENTRY_W = 64;
    localparam int unsigned HALF_W  = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;
endpackage

// File: rtl/spad_addr_map.sv
module spad_addr_map #(
    parameter int LANES  = 32,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 6,
    localparam int ADDR_W = 3 + BANK_W + ROW_W
) (
    input  logic                              wide_mode,
    input  logic [LANES-1:0][ADDR_W-1:0]      lane_addr,
    output logic [LANES-1:0][BANK_W-1:0]      lane_bank,
    output logic [LANES-1:0][ROW_W-1:0]       lane_row,
    output logic [LANES-1:0]                  lane_half
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] a;
        logic              byte_bits_unused;

        assign a                = lane_addr[g];
        assign byte_bits_unused = ^a[1:0];
        assign lane_row[g]      = a[3 + BANK_W +: ROW_W];

        always_comb begin
            if (wide_mode) begin
                lane_bank[g] = a[3 +: BANK_W];
                lane_half[g] = 1'b0;
            end else begin
                lane_bank[g] = a[2 +: BANK_W];
                lane_half[g] = a[2 + BANK_W];
            end
        end
    end
endmodule

// File: rtl/spad_pass_select.sv
module spad_pass_select #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int BANK_W = 5,
    parameter int ROW_W  = 6,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                            wide_mode,
    input  logic [LANES-1:0]                pending,
    input  logic [LANES-1:0][BANK_W-1:0]    lane_bank,
    input  logic [LANES-1:0][ROW_W-1:0]     lane_row,
    input  logic [LANES-1:0]                lane_half,
    output logic [BANKS-1:0]                bank_req,
    output logic [BANKS-1:0][ROW_W-1:0]     bank_row,
    output logic [BANKS-1:0]                lo_en,
    output logic [BANKS-1:0]                hi_en,
    output logic [BANKS-1:0][LANE_W-1:0]    lo_lane,
    output logic [BANKS-1:0][LANE_W-1:0]    hi_lane,
    output logic [LANES-1:0]                serve
);
    // Per bank: the lowest pending lane fixes the row; writers per half
    // are chosen lowest-first among lanes hitting that row.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic              found;
        logic [ROW_W-1:0]  row_sel;
        logic              lo_f, hi_f;
        logic [LANE_W-1:0] lo_i, hi_i;

        always_comb begin
            found   = 1'b0;
            row_sel = '0;
            for (int t = 0; t < LANES; t++) begin
                if (!found && pending[t] && (lane_bank[t] == BANK_W'(b))) begin
                    found   = 1'b1;
                    row_sel = lane_row[t];
                end
            end
            lo_f = 1'b0;
            hi_f = 1'b0;
            lo_i = '0;
            hi_i = '0;
            for (int t = LANES - 1; t >= 0; t--) begin
                if (pending[t] && (lane_bank[t] == BANK_W'(b)) && (lane_row[t] == row_sel)) begin
                    if (wide_mode || !lane_half[t]) begin
                        lo_f = 1'b1;
                        lo_i = LANE_W'(t);
                    end
                    if (wide_mode || lane_half[t]) begin
                        hi_f = 1'b1;
                        hi_i = LANE_W'(t);
                    end
                end
            end
        end

        assign bank_req[b] = found;
        assign bank_row[b] = row_sel;
        assign lo_en[b]    = lo_f;
        assign hi_en[b]    = hi_f;
        assign lo_lane[b]  = lo_i;
        assign hi_lane[b]  = hi_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_serve
        assign serve[g] = pending[g] && bank_req[lane_bank[g]]
                          && (bank_row[lane_bank[g]] == lane_row[g]);
    end
endmodule

// File: rtl/spad_bank_array.sv
module spad_bank_array
    import spad_pkg::*;
#(
    parameter int BANKS = 32,
    parameter int ROW_W = 6,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic                           clk,
    input  logic [BANKS-1:0][ROW_W-1:0]    row_sel,
    input  logic [BANKS-1:0]               wr_lo_en,
    input  logic [BANKS-1:0]               wr_hi_en,
    input  logic [BANKS-1:0][HALF_W-1:0]   wr_lo_data,
    input  logic [BANKS-1:0][HALF_W-1:0]   wr_hi_data,
    output logic [BANKS-1:0][ENTRY_W-1:0]  rd_entry
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic [ENTRY_W-1:0] mem [ROWS];

        always_ff @(posedge clk) begin
            if (wr_lo_en[g]) mem[row_sel[g]][HALF_W-1:0]       <= wr_lo_data[g];
            if (wr_hi_en[g]) mem[row_sel[g]][ENTRY_W-1:HALF_W] <= wr_hi_data[g];
        end

        assign rd_entry[g] = mem[row_sel[g]];
    end
endmodule

// File: rtl/spad_conflict_resolver.sv
module spad_conflict_resolver
    import spad_pkg::*;
#(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROW_W = 6,
    localparam int BANK_W = $clog2(BANKS),
    localparam int LANE_W = $clog2(LANES),
    localparam int ADDR_W = 3 + BANK_W + ROW_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    output logic                        acc_ready,
    input  logic                        acc_write,
    input  logic                        acc_wide,
    input  logic [LANES-1:0]            acc_mask,
    input  logic [LANES*ADDR_W-1:0]     acc_addr,
    input  logic [LANES*ENTRY_W-1:0]    acc_wdata,
    output logic [BANKS-1:0]            bank_req,
    output logic                        acc_done,
    output logic [LANE_W-1:0]           acc_replays,
    output logic [LANES*ENTRY_W-1:0]    lane_rdata
);
    typedef struct packed {
        seq_state_e                        state;
        logic                              write;
        logic                              wide;
        logic [LANES-1:0]                  pending;
        logic [LANES-1:0][ADDR_W-1:0]      addr;
        logic [LANES-1:0][ENTRY_W-1:0]     wdata;
        logic [LANE_W-1:0]                 pass_idx;
        logic [LANES-1:0][ENTRY_W-1:0]     rdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic done_d;

    logic [LANES-1:0][BANK_W-1:0]  lane_bank;
    logic [LANES-1:0][ROW_W-1:0]   lane_row;
    logic [LANES-1:0]              lane_half;
    logic [BANKS-1:0]              req_w;
    logic [BANKS-1:0][ROW_W-1:0]   row_w;
    logic [BANKS-1:0]              lo_en_w, hi_en_w;
    logic [BANKS-1:0][LANE_W-1:0]  lo_lane_w, hi_lane_w;
    logic [LANES-1:0]              serve_w;
    logic [BANKS-1:0]              wr_lo_en, wr_hi_en;
    logic [BANKS-1:0][HALF_W-1:0]  wr_lo_data, wr_hi_data;
    logic [BANKS-1:0][ENTRY_W-1:0] rd_entry;

    spad_addr_map #(.LANES(LANES), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_map (
        .wide_mode (seq_q.wide),
        .lane_addr (seq_q.addr),
        .lane_bank (lane_bank),
        .lane_row  (lane_row),
        .lane_half (lane_half)
    );

    spad_pass_select #(.LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_sel (
        .wide_mode (seq_q.wide),
        .pending   (seq_q.pending),
        .lane_bank (lane_bank),
        .lane_row  (lane_row),
        .lane_half (lane_half),
        .bank_req  (req_w),
        .bank_row  (row_w),
        .lo_en     (lo_en_w),
        .hi_en     (hi_en_w),
        .lo_lane   (lo_lane_w),
        .hi_lane   (hi_lane_w),
        .serve     (serve_w)
    );

    // Write port shaping: the chosen lane per half drives each bank.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            wr_lo_en[b]   = seq_q.write && lo_en_w[b];
            wr_hi_en[b]   = seq_q.write && hi_en_w[b];
            wr_lo_data[b] = seq_q.wdata[lo_lane_w[b]][HALF_W-1:0];
            if (seq_q.wide) begin
                wr_hi_data[b] = seq_q.wdata[hi_lane_w[b]][ENTRY_W-1:HALF_W];
            end else begin
                wr_hi_data[b] = seq_q.wdata[hi_lane_w[b]][HALF_W-1:0];
            end
        end
    end

    spad_bank_array #(.BANKS(BANKS), .ROW_W(ROW_W)) u_banks (
        .clk        (clk),
        .row_sel    (row_w),
        .wr_lo_en   (wr_lo_en),
        .wr_hi_en   (wr_hi_en),
        .wr_lo_data (wr_lo_data),
        .wr_hi_data (wr_hi_data),
        .rd_entry   (rd_entry)
    );

    always_comb begin
        seq_d  = seq_q;
        done_d = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (acc_valid) begin
                    seq_d.state    = ST_BUSY;
                    seq_d.write    = acc_write;
                    seq_d.wide     = acc_wide;
                    seq_d.pending  = acc_mask;
                    seq_d.addr     = acc_addr;
                    seq_d.wdata    = acc_wdata;
                    seq_d.pass_idx = '0;
                end
            end
            ST_BUSY: begin
                seq_d.pending = seq_q.pending & ~serve_w;
                for (int t = 0; t < LANES; t++) begin
                    if (serve_w[t] && !seq_q.write) begin
                        if (seq_q.wide) begin
                            seq_d.rdata[t] = rd_entry[lane_bank[t]];
                        end else if (lane_half[t]) begin
                            seq_d.rdata[t] = {{HALF_W{1'b0}}, rd_entry[lane_bank[t]][ENTRY_W-1:HALF_W]};
                        end else begin
                            seq_d.rdata[t] = {{HALF_W{1'b0}}, rd_entry[lane_bank[t]][HALF_W-1:0]};
                        end
                    end
                end
                if (seq_d.pending == '0) begin
                    done_d      = 1'b1;
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.pass_idx = seq_q.pass_idx + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign acc_ready   = (seq_q.state == ST_IDLE);
    assign bank_req    = req_w;
    assign acc_done    = done_d;
    assign acc_replays = seq_q.pass_idx;
    assign lane_rdata  = seq_q.rdata;
endmodule

// File: rtl/spad_conflict_checker.sv
module spad_conflict_checker #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    localparam int LANE_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              acc_done,
    input logic [LANE_W-1:0] acc_replays,
    input logic [BANKS-1:0]  bank_req
);
    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> (!acc_done && acc_ready));

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> !acc_ready);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |-> (bank_req == '0));

    assert_first_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> (acc_replays == '0));

    assert_replay_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ready && !acc_done) |=> (acc_replays == LANE_W'($past(acc_replays) + 1'b1)));
endmodule

bind spad_conflict_resolver spad_conflict_checker #(.LANES(LANES), .BANKS(BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_ready   (acc_ready),
    .acc_done    (acc_done),
    .acc_replays (acc_replays),
    .bank_req    (bank_req)
);

// File: tb/spad_conflict_resolver_tb_top.sv
module spad_conflict_resolver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int BANKS  = 32;
    localparam int ROW_W  = 6;
    localparam int ADDR_W = 14;
    localparam int LANE_W = 5;
    localparam int ENT    = 64;
    localparam int NENT   = BANKS << ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic                    acc_valid = 1'b0;
    logic                    acc_ready;
    logic                    acc_write = 1'b0;
    logic                    acc_wide = 1'b0;
    logic [LANES-1:0]        acc_mask = '0;
    logic [LANES*ADDR_W-1:0] acc_addr = '0;
    logic [LANES*ENT-1:0]    acc_wdata = '0;
    logic [BANKS-1:0]        bank_req;
    logic                    acc_done;
    logic [LANE_W-1:0]       acc_replays;
    logic [LANES*ENT-1:0]    lane_rdata;

    spad_conflict_resolver #(.LANES(LANES), .BANKS(BANKS), .ROW_W(ROW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_wide(acc_wide), .acc_mask(acc_mask),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .bank_req(bank_req),
        .acc_done(acc_done), .acc_replays(acc_replays), .lane_rdata(lane_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [ENT-1:0]    shadow [NENT];
    logic [ENT-1:0]    exp_rd [LANES];
    logic [ADDR_W-1:0] s_addr [LANES];
    logic [ENT-1:0]    s_wdata [LANES];
    logic [BANKS-1:0]  pass_req [LANES + 2];
    bit                order_chk = 1'b0;
    int                got_passes;

    task automatic check_eq(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int bank_of(logic [ADDR_W-1:0] a, bit wide);
        return wide ? int'(a[7:3]) : int'(a[6:2]);
    endfunction

    function automatic int row_of(logic [ADDR_W-1:0] a);
        return int'(a[13:8]);
    endfunction

    function automatic int ent_of(logic [ADDR_W-1:0] a, bit wide);
        return row_of(a) * BANKS + bank_of(a, wide);
    endfunction

    function automatic logic [63:0] fill_val(int i);
        return {32'(i) ^ 32'hC0DE0000, 32'(i * 7 + 3)};
    endfunction

    function automatic int model_replays(bit wide, logic [LANES-1:0] mask);
        int worst;
        worst = 0;
        for (int b = 0; b < BANKS; b++) begin
            int cnt;
            cnt = 0;
            for (int t = 0; t < LANES; t++) begin
                if (mask[t] && bank_of(s_addr[t], wide) == b) begin
                    bit seen;
                    seen = 1'b0;
                    for (int u = 0; u < t; u++) begin
                        if (mask[u] && bank_of(s_addr[u], wide) == b && row_of(s_addr[u]) == row_of(s_addr[t]))
                            seen = 1'b1;
                    end
                    if (!seen) cnt++;
                end
            end
            if (cnt > worst) worst = cnt;
        end
        return (worst == 0) ? 0 : worst - 1;
    endfunction

    function automatic logic [63:0] model_read(int t, bit wide);
        logic [63:0] e;
        e = shadow[ent_of(s_addr[t], wide)];
        if (wide) return e;
        return s_addr[t][7] ? {32'h0, e[63:32]} : {32'h0, e[31:0]};
    endfunction

    // Runs one access; checks handshake, replay count and all lane results.
    task automatic run_access(bit wr, bit wide, logic [LANES-1:0] mask, string tag);
        logic [63:0] exp_new [LANES];
        int er;
        int passes;
        int rep;
        bit done_seen;
        er = model_replays(wide, mask);
        for (int t = 0; t < LANES; t++) begin
            exp_new[t] = exp_rd[t];
            if (!wr && mask[t]) exp_new[t] = model_read(t, wide);
        end
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_wide  = wide;
        acc_mask  = mask;
        for (int t = 0; t < LANES; t++) begin
            acc_addr[t*ADDR_W +: ADDR_W] = s_addr[t];
            acc_wdata[t*ENT +: ENT]      = s_wdata[t];
        end
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        passes = 0;
        rep = 0;
        done_seen = 1'b0;
        while (!done_seen) begin
            if (acc_ready !== 1'b0) check_eq("R8", "ready during pass", 64'(acc_ready), 64'd0);
            if (passes < LANES + 2) pass_req[passes] = bank_req;
            if (order_chk && passes >= 1 && passes <= LANES)
                check_eq("R5", $sformatf("ascending service lane %0d", passes - 1),
                         lane_rdata[(passes-1)*ENT +: ENT], exp_new[passes-1]);
            if (acc_done) begin
                done_seen = 1'b1;
                rep = int'(acc_replays);
            end
            passes++;
            @(negedge clk);
        end
        got_passes = passes;
        check_eq("R8", "ready after done", 64'(acc_ready), 64'd1);
        check_eq("R8", "done is single cycle", 64'(acc_done), 64'd0);
        check_eq(tag, "replay count", 64'(rep), 64'(er));
        check_eq("R4", "passes = replays + 1", 64'(passes), 64'(er + 1));
        if (wr) begin
            for (int t = LANES - 1; t >= 0; t--) begin
                if (mask[t]) begin
                    int ix;
                    ix = ent_of(s_addr[t], wide);
                    if (wide) shadow[ix] = s_wdata[t];
                    else if (s_addr[t][7]) shadow[ix][63:32] = s_wdata[t][31:0];
                    else shadow[ix][31:0] = s_wdata[t][31:0];
                end
            end
        end
        for (int t = 0; t < LANES; t++) begin
            check_eq((mask[t] && !wr) ? tag : "R7", $sformatf("lane %0d rdata", t),
                     lane_rdata[t*ENT +: ENT], exp_new[t]);
            exp_rd[t] = exp_new[t];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] w0;
        for (int t = 0; t < LANES; t++) exp_rd[t] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check_eq("R9", "ready", 64'(acc_ready), 64'd1);
        check_eq("R9", "done", 64'(acc_done), 64'd0);
        check_eq("R9", "bank_req", 64'(bank_req), 64'd0);
        check_eq("R9", "replays", 64'(acc_replays), 64'd0);
        check_eq("R9", "lane 0 rdata", lane_rdata[63:0], 64'd0);
        check_eq("R9", "lane 31 rdata", lane_rdata[31*ENT +: ENT], 64'd0);

        // R1: fill every entry with consecutive 8-byte words, one pass each
        for (int blk = 0; blk < NENT / LANES; blk++) begin
            for (int t = 0; t < LANES; t++) begin
                s_addr[t]  = ADDR_W'((blk * LANES + t) * 8);
                s_wdata[t] = fill_val(blk * LANES + t);
            end
            run_access(1'b1, 1'b1, '1, "R1");
        end

        // R4/R5: 32x32 column walk, stride 32 -> all lanes in bank 5
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'((t * 32 + 5) * 8);
        order_chk = 1'b1;
        run_access(1'b0, 1'b1, '1, "R4");
        order_chk = 1'b0;
        check_eq("R4", "column stride 32 passes", 64'(got_passes), 64'd32);
        for (int p = 0; p < LANES; p++)
            check_eq("R5", $sformatf("column pass %0d bank_req", p), 64'(pass_req[p]), 64'(32'h1 << 5));

        // R1: same column with padded stride 33 -> conflict free
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'((t * 33 + 5) * 8);
        run_access(1'b0, 1'b1, '1, "R1");
        check_eq("R5", "stride 33 bank_req", 64'(pass_req[0]), 64'hFFFF_FFFF);

        // R3: every lane reads a byte of one word -> multicast
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(14'h1238 + (t % 8));
        run_access(1'b0, 1'b1, '1, "R3");
        check_eq("R3", "multicast bank_req", 64'(pass_req[0]), 64'(32'h1 << 7));

        // R4: conflict degree sweep 1..32
        for (int k = 1; k <= LANES; k++) begin
            for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(((t % k) * BANKS + (t / k) % BANKS) * 8);
            run_access(1'b0, 1'b1, '1, "R4");
        end

        // R2: 4-byte mode consecutive words
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(t * 4 + (t % 4));
        run_access(1'b0, 1'b0, '1, "R2");
        // R3: both halves of one entry in the same pass
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'((t / 2) * 4 + (t % 2) * 128);
        run_access(1'b0, 1'b0, '1, "R3");
        // R2: 4-byte mode stride 256 -> one bank, 32 rows
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(t * 256 + 12);
        run_access(1'b0, 1'b0, '1, "R2");

        // R7: masked column walk and empty mask
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'((t * 32 + 9) * 8);
        run_access(1'b0, 1'b1, 32'h5555_5555, "R7");
        run_access(1'b0, 1'b1, '0, "R7");
        check_eq("R7", "empty mask bank_req", 64'(pass_req[0]), 64'd0);

        // R6: all lanes write one location, lowest lane must win
        for (int t = 0; t < LANES; t++) begin
            s_addr[t]  = ADDR_W'(14'h0400);
            s_wdata[t] = 64'hABCD_0000_0000_0000 + 64'(t * 3 + 1);
        end
        w0 = s_wdata[0];
        run_access(1'b1, 1'b1, '1, "R6");
        run_access(1'b0, 1'b1, '1, "R6");
        check_eq("R6", "winner value", lane_rdata[3*ENT +: ENT], w0);

        // R10: 4-byte writes of both halves, then full-entry read back
        for (int t = 0; t < LANES; t++) begin
            s_addr[t]  = ADDR_W'((t / 2) * 4 + (t % 2) * 128 + 512);
            s_wdata[t] = {32'hDEAD_BEEF, 32'h5100_0000 + 32'(t)};
        end
        run_access(1'b1, 1'b0, '1, "R10");
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(512 + t * 8);
        run_access(1'b0, 1'b1, '1, "R10");
        // R10: single upper-half write leaves lower half intact
        for (int t = 0; t < LANES; t++) begin
            s_addr[t]  = ADDR_W'(1024 + 128 + t * 4);
            s_wdata[t] = {32'hFFFF_FFFF, 32'h7700_0000 + 32'(t)};
        end
        run_access(1'b1, 1'b0, 32'h0000_00FF, "R10");
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(1024 + t * 8);
        run_access(1'b0, 1'b1, '1, "R10");
        for (int t = 0; t < LANES; t++) s_addr[t] = ADDR_W'(1024 + 128 + t * 4);
        run_access(1'b0, 1'b0, '1, "R10");

        // R7: masked write leaves inactive lanes' entries untouched
        for (int t = 0; t < LANES; t++) begin
            s_addr[t]  = ADDR_W'((40 * BANKS + t) * 8);
            s_wdata[t] = 64'h0BAD_0000_0000_0000 + 64'(t);
        end
        run_access(1'b1, 1'b1, 32'h0000_FFFF, "R7");
        run_access(1'b0, 1'b1, '1, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule